// File: doc/BRIEF.md
# Multiplexed External Data Bus Sequencer

This block generates the external data-memory read and write cycles of a small 8-bit microcontroller core. It runs on the CPU clock. Each external access takes a fixed number of CPU clocks. The low address byte and the data share one multiplexed port. A separate high-address port carries the upper byte. An address latch enable strobe marks the address phase, and active-low read and write strobes mark the data phase.

The core presents one request. The request carries a direction, an addressing mode, the address bytes, the write data, a stretch bit, a page-mode bit and the value of the high-port latch. All of these are captured on acceptance. The sequencer ends every access with a one-clock done pulse. On reads it also returns the sampled byte. The multiplexed port is modelled as a separate output, output-enable and input, so a pad ring or a test bench can resolve it.

Top module: `ext_bus_seq`

## Requirements
- R1: With the stretch bit clear, an access lasts 6 CPU clocks. The first clock is the one in which address latch enable is high, and the last is the one carrying the done pulse. The read or write strobe is low for 3 of those clocks.
- R2: With the stretch bit set, the strobe is low for 15 clocks and the access lasts 18 clocks.
- R3: Address latch enable is high for exactly the first clock of an access, with the output enable high and the low address on the multiplexed port. It is low again in the second clock, before any strobe falls.
- R4: On reads, the multiplexed output enable is low from the second clock to the end of the access. The read data is the value on the bus input during the last clock in which the read strobe is low. It appears on `rsp_rdata` in the done clock and is held until the next read.
- R5: On writes, the write data is driven with the output enable high from the second clock through the done clock. This covers the whole strobe and one clock after it rises.
- R6: When `req_ptr_mode` is 0 (8-bit register-indirect), the high-address port shows `req_port_latch` for the whole access.
- R7: When `req_ptr_mode` is 1 (16-bit pointer) and `req_page_mode` is 0, the high-address port shows `req_addr_hi` for the whole access.
- R8: When `req_ptr_mode` is 1 and `req_page_mode` is 1, the high-address port shows `req_port_latch` instead of `req_addr_hi`.
- R9: The read strobe and the write strobe are never low in the same clock.
- R10: A request is accepted only while no access is in progress. Requests presented from acceptance through the done clock start no access.
- R11: `rsp_done` is high for exactly one clock, the final clock of the access.
- R12: After reset, address latch enable and `rsp_done` are low, both strobes are high, and the multiplexed output enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request, taken when idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_ptr_mode | input | 1 | 1 = 16-bit pointer, 0 = 8-bit register-indirect |
| req_addr_lo | input | 8 | Pointer low byte or index register value |
| req_addr_hi | input | 8 | Pointer high byte |
| req_wdata | input | 8 | Write data |
| req_stretch | input | 1 | Stretch the strobe to the long width |
| req_page_mode | input | 1 | Page-access mode for pointer accesses |
| req_port_latch | input | 8 | High-port latch contents |
| rsp_done | output | 1 | One-clock pulse on the final clock of an access |
| rsp_rdata | output | 8 | Read data |
| bus_ad_out | output | 8 | Multiplexed address/data output |
| bus_ad_oe | output | 1 | Drive enable for the multiplexed port |
| bus_ad_in | input | 8 | Multiplexed port input |
| bus_hi | output | 8 | High-address port |
| bus_ale | output | 1 | Address latch enable |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_wr_n | output | 1 | Write strobe, active low |

## Verification
The bench builds the block with its default parameters: 8-bit ports, a normal strobe width of 3 and a stretched strobe width of 15. Both the 6-clock and 18-clock access lengths are therefore exercised. The bench drives the correct read byte only during the last low clock of the read strobe, so any other sampling clock returns a wrong value. Extra requests are raised during busy clocks to show that they start no cycle. Each high-port source is selected at least once.

// File: rtl/ext_bus_pkg.sv
package ext_bus_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ADDR,
    PH_SETUP,
    PH_STROBE,
    PH_RECOVER
  } xb_phase_e;
endpackage

// File: rtl/xb_phase_ctrl.sv
module xb_phase_ctrl
  import ext_bus_pkg::*;
#(
  parameter int NORM_W = 3,
  parameter int LONG_W = 15
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      start,
  input  logic      start_write,
  input  logic      start_stretch,
  output xb_phase_e phase_q,
  output xb_phase_e phase_nxt,
  output logic      write_nxt,
  output logic      sample_rd,
  output logic      ale_q,
  output logic      rd_n_q,
  output logic      wr_n_q,
  output logic      done_q
);
  localparam int CW = $clog2(LONG_W + 1);
  localparam logic [CW-1:0] NORM_LAST = CW'(NORM_W - 1);
  localparam logic [CW-1:0] LONG_LAST = CW'(LONG_W - 1);

  logic [CW-1:0] cnt_q, cnt_nxt;
  logic          write_q, stretch_q;
  logic          strobe_last;

  assign strobe_last = (cnt_q == (stretch_q ? LONG_LAST : NORM_LAST));
  assign write_nxt   = start ? start_write : write_q;
  assign sample_rd   = (phase_q == PH_STROBE) && strobe_last && !write_q;

  always_comb begin
    phase_nxt = phase_q;
    cnt_nxt   = cnt_q;
    unique case (phase_q)
      PH_IDLE:    if (start) phase_nxt = PH_ADDR;
      PH_ADDR:    phase_nxt = PH_SETUP;
      PH_SETUP: begin
        phase_nxt = PH_STROBE;
        cnt_nxt   = '0;
      end
      PH_STROBE: begin
        if (strobe_last) phase_nxt = PH_RECOVER;
        else             cnt_nxt   = cnt_q + 1'b1;
      end
      PH_RECOVER: phase_nxt = PH_IDLE;
      default:    phase_nxt = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q   <= PH_IDLE;
      cnt_q     <= '0;
      write_q   <= 1'b0;
      stretch_q <= 1'b0;
      ale_q     <= 1'b0;
      rd_n_q    <= 1'b1;
      wr_n_q    <= 1'b1;
      done_q    <= 1'b0;
    end else begin
      phase_q <= phase_nxt;
      cnt_q   <= cnt_nxt;
      if (start) begin
        write_q   <= start_write;
        stretch_q <= start_stretch;
      end
      ale_q  <= (phase_nxt == PH_ADDR);
      rd_n_q <= !((phase_nxt == PH_STROBE) && !write_nxt);
      wr_n_q <= !((phase_nxt == PH_STROBE) && write_nxt);
      done_q <= (phase_nxt == PH_RECOVER);
    end
  end
endmodule

// File: rtl/xb_addr_path.sv
module xb_addr_path #(
  parameter int HI_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic            ptr_mode,
  input  logic            page_mode,
  input  logic [HI_W-1:0] addr_hi,
  input  logic [HI_W-1:0] port_latch,
  output logic [HI_W-1:0] hi_q
);
  logic [HI_W-1:0] hi_sel;

  // Pointer high byte only for full pointer accesses outside page mode.
  assign hi_sel = (ptr_mode && !page_mode) ? addr_hi : port_latch;

  always_ff @(posedge clk) begin
    if (rst)        hi_q <= '0;
    else if (start) hi_q <= hi_sel;
  end
endmodule

// File: rtl/xb_data_path.sv
module xb_data_path
  import ext_bus_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  xb_phase_e     phase_nxt,
  input  logic          write_nxt,
  input  logic          sample_rd,
  input  logic [DW-1:0] addr_lo,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] ad_in,
  output logic [DW-1:0] ad_out_q,
  output logic          ad_oe_q,
  output logic [DW-1:0] rdata_q
);
  logic [DW-1:0] wdata_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      wdata_q  <= '0;
      ad_out_q <= '0;
      ad_oe_q  <= 1'b0;
      rdata_q  <= '0;
    end else begin
      if (start) wdata_q <= wdata;
      if (sample_rd) rdata_q <= ad_in;
      if (start) begin
        ad_out_q <= addr_lo;
        ad_oe_q  <= 1'b1;
      end else begin
        unique case (phase_nxt)
          PH_SETUP, PH_STROBE, PH_RECOVER: begin
            ad_out_q <= wdata_q;
            ad_oe_q  <= write_nxt;
          end
          default: ad_oe_q <= 1'b0;
        endcase
      end
    end
  end
endmodule

// File: rtl/ext_bus_seq.sv
module ext_bus_seq
  import ext_bus_pkg::*;
#(
  parameter int DW     = 8,
  parameter int HI_W   = 8,
  parameter int NORM_W = 3,
  parameter int LONG_W = 15
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req_valid,
  input  logic            req_write,
  input  logic            req_ptr_mode,
  input  logic [DW-1:0]   req_addr_lo,
  input  logic [HI_W-1:0] req_addr_hi,
  input  logic [DW-1:0]   req_wdata,
  input  logic            req_stretch,
  input  logic            req_page_mode,
  input  logic [HI_W-1:0] req_port_latch,
  output logic            rsp_done,
  output logic [DW-1:0]   rsp_rdata,
  output logic [DW-1:0]   bus_ad_out,
  output logic            bus_ad_oe,
  input  logic [DW-1:0]   bus_ad_in,
  output logic [HI_W-1:0] bus_hi,
  output logic            bus_ale,
  output logic            bus_rd_n,
  output logic            bus_wr_n
);
  xb_phase_e phase_q, phase_nxt;
  logic      start, write_nxt, sample_rd;

  // Requests are taken only from the idle phase; all others are dropped.
  assign start = req_valid && (phase_q == PH_IDLE);

  xb_phase_ctrl #(.NORM_W(NORM_W), .LONG_W(LONG_W)) u_ctrl (
    .clk(clk), .rst(rst), .start(start),
    .start_write(req_write), .start_stretch(req_stretch),
    .phase_q(phase_q), .phase_nxt(phase_nxt), .write_nxt(write_nxt),
    .sample_rd(sample_rd), .ale_q(bus_ale), .rd_n_q(bus_rd_n),
    .wr_n_q(bus_wr_n), .done_q(rsp_done)
  );

  xb_addr_path #(.HI_W(HI_W)) u_addr (
    .clk(clk), .rst(rst), .start(start),
    .ptr_mode(req_ptr_mode), .page_mode(req_page_mode),
    .addr_hi(req_addr_hi), .port_latch(req_port_latch), .hi_q(bus_hi)
  );

  xb_data_path #(.DW(DW)) u_data (
    .clk(clk), .rst(rst), .start(start), .phase_nxt(phase_nxt),
    .write_nxt(write_nxt), .sample_rd(sample_rd),
    .addr_lo(req_addr_lo), .wdata(req_wdata), .ad_in(bus_ad_in),
    .ad_out_q(bus_ad_out), .ad_oe_q(bus_ad_oe), .rdata_q(rsp_rdata)
  );
endmodule

// File: rtl/xb_bus_checker.sv
module xb_bus_checker #(
  parameter int HI_W   = 8,
  parameter int NORM_W = 3,
  parameter int LONG_W = 15
) (
  input logic            clk,
  input logic            rst,
  input logic            rsp_done,
  input logic            bus_ad_oe,
  input logic [HI_W-1:0] bus_hi,
  input logic            bus_ale,
  input logic            bus_rd_n,
  input logic            bus_wr_n
);
  logic strobe_any;
  int   str_cnt, len_cnt;
  assign strobe_any = !bus_rd_n || !bus_wr_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      str_cnt <= 0;
      len_cnt <= 0;
    end else begin
      if (strobe_any)      str_cnt <= str_cnt + 1;
      else if (!bus_ale)   str_cnt <= str_cnt;
      else                 str_cnt <= 0;
      if (rsp_done)        len_cnt <= 0;
      else if (bus_ale)    len_cnt <= 1;
      else if (len_cnt != 0) len_cnt <= len_cnt + 1;
    end
  end

  // R9
  a_r9_strobe_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(!bus_rd_n && !bus_wr_n));
  // R3
  a_r3_ale_no_strobe: assert property (@(posedge clk) disable iff (rst)
    bus_ale |-> (bus_rd_n && bus_wr_n && bus_ad_oe));
  // R3
  a_r3_ale_single: assert property (@(posedge clk) disable iff (rst)
    bus_ale |=> !bus_ale);
  // R4
  a_r4_read_released: assert property (@(posedge clk) disable iff (rst)
    !bus_rd_n |-> !bus_ad_oe);
  // R5
  a_r5_write_driven: assert property (@(posedge clk) disable iff (rst)
    !bus_wr_n |-> bus_ad_oe);
  // R5
  a_r5_write_hold: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_wr_n) |-> bus_ad_oe);
  // R6
  a_r6_hi_stable: assert property (@(posedge clk) disable iff (rst)
    strobe_any |-> $stable(bus_hi));
  // R11
  a_r11_done_pulse: assert property (@(posedge clk) disable iff (rst)
    rsp_done |=> !rsp_done);
  // R2
  a_r2_strobe_width: assert property (@(posedge clk) disable iff (rst)
    ($fell(strobe_any) && (str_cnt != 0)) |-> (str_cnt == NORM_W || str_cnt == LONG_W));
  // R1
  a_r1_cycle_len: assert property (@(posedge clk) disable iff (rst)
    rsp_done |-> (len_cnt == NORM_W + 2 || len_cnt == LONG_W + 2));
endmodule

bind ext_bus_seq xb_bus_checker #(.HI_W(HI_W), .NORM_W(NORM_W), .LONG_W(LONG_W)) u_chk (
  .clk(clk), .rst(rst), .rsp_done(rsp_done), .bus_ad_oe(bus_ad_oe),
  .bus_hi(bus_hi), .bus_ale(bus_ale), .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n)
);

// File: tb/test_ext_bus_seq.sv
module test_ext_bus_seq;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    bit       wr;
    bit [7:0] lo, hi, data;
    int       len, sw;
  } exp_t;

  logic clk = 0, rst = 1;
  logic req_valid = 0, req_write = 0, req_ptr_mode = 0, req_stretch = 0, req_page_mode = 0;
  logic [7:0] req_addr_lo = 0, req_addr_hi = 0, req_wdata = 0, req_port_latch = 0;
  logic [7:0] bus_ad_in = 0;
  logic rsp_done, bus_ad_oe, bus_ale, bus_rd_n, bus_wr_n;
  logic [7:0] rsp_rdata, bus_ad_out, bus_hi;

  int n_chk = 0, n_bad = 0, cyc = 0;
  exp_t q[$];
  exp_t cur;
  bit in_cyc = 0;
  int k = 0, sw = 0;
  logic [7:0] hi0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ext_bus_seq i_ext_bus_seq (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_ptr_mode(req_ptr_mode), .req_addr_lo(req_addr_lo), .req_addr_hi(req_addr_hi),
    .req_wdata(req_wdata), .req_stretch(req_stretch), .req_page_mode(req_page_mode),
    .req_port_latch(req_port_latch), .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
    .bus_ad_out(bus_ad_out), .bus_ad_oe(bus_ad_oe), .bus_ad_in(bus_ad_in),
    .bus_hi(bus_hi), .bus_ale(bus_ale), .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n)
  );

  task automatic chk(bit ok, string tag, int act, int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  // Monitor: reconstructs each access from the pins and compares with the queue.
  always @(negedge clk) begin
    if (rst) in_cyc = 0;
    else begin
      chk(!(!bus_rd_n && !bus_wr_n), "R9 strobes overlap", {bus_rd_n, bus_wr_n}, 3);
      if (!in_cyc) begin
        chk(!rsp_done, "R11 done outside access", rsp_done, 0);
        if (bus_ale) begin
          if (q.size() == 0) chk(0, "R10 unexpected access", 1, 0);
          else begin
            cur = q.pop_front();
            in_cyc = 1; k = 0; sw = 0; hi0 = bus_hi;
            chk(bus_ad_oe && bus_ad_out == cur.lo, "R3 low address phase", bus_ad_out, cur.lo);
            chk(bus_hi == cur.hi, "R6/R7/R8 high port", bus_hi, cur.hi);
          end
        end
      end else begin
        k++;
        if (cur.wr ? !bus_wr_n : !bus_rd_n) sw++;
        if (!cur.wr) bus_ad_in = (!bus_rd_n && sw == cur.sw) ? cur.data : ~cur.data;
        chk(bus_hi == hi0, "R6 high port stable", bus_hi, hi0);
        if (k == 1) chk(!bus_ale && bus_rd_n && bus_wr_n, "R3 ale low before strobe", bus_ale, 0);
        if (k >= 1 && cur.wr)
          chk(bus_ad_oe && bus_ad_out == cur.data, "R5 write data driven", bus_ad_out, cur.data);
        if (k >= 1 && !cur.wr) chk(!bus_ad_oe, "R4 port released", bus_ad_oe, 0);
        if (rsp_done || k > 40) begin
          chk(k == cur.len - 1, cur.sw == 3 ? "R1 access length" : "R2 access length", k + 1, cur.len);
          chk(sw == cur.sw, "R1/R2 strobe width", sw, cur.sw);
          chk(rsp_done, "R11 done on final clock", rsp_done, 1);
          if (!cur.wr) chk(rsp_rdata == cur.data, "R4 read data", rsp_rdata, cur.data);
          in_cyc = 0;
        end
      end
    end
  end

  // Driver: queues the expected access, raises the request, optionally adds busy-time requests.
  task automatic txn(bit wr, bit ptr, bit page, bit stretch, bit [7:0] lo, bit [7:0] hi,
                     bit [7:0] latch, bit [7:0] data, bit noise);
    exp_t e;
    e.wr = wr; e.lo = lo; e.data = data;
    e.hi = (ptr && !page) ? hi : latch;
    e.sw = stretch ? 15 : 3;
    e.len = e.sw + 3;
    q.push_back(e);
    @(negedge clk);
    req_valid = 1; req_write = wr; req_ptr_mode = ptr; req_page_mode = page;
    req_stretch = stretch; req_addr_lo = lo; req_addr_hi = hi;
    req_port_latch = latch; req_wdata = data;
    @(negedge clk);
    req_valid = 0;
    if (noise) begin
      for (int i = 0; i < 3; i++) begin
        @(negedge clk);
        req_valid = 1; req_write = ~wr; req_addr_lo = 8'hEE; req_wdata = 8'h11;
        req_addr_hi = 8'h77; req_port_latch = 8'h66;
      end
      @(negedge clk);
      req_valid = 0;
    end
    while (!rsp_done) @(negedge clk);
    @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!bus_ale && bus_rd_n && bus_wr_n && !rsp_done && !bus_ad_oe, "R12 reset state",
        {bus_ale, bus_rd_n, bus_wr_n, rsp_done, bus_ad_oe}, 5'b01100);
    rst = 0;
    @(negedge clk);
    // R7 pointer write, R1 normal length
    txn(1, 1, 0, 0, 8'h34, 8'h12, 8'hA5, 8'hC3, 0);
    // R4 pointer read
    txn(0, 1, 0, 0, 8'h78, 8'h56, 8'hA5, 8'h9E, 0);
    // R6 register-indirect read uses the latch
    txn(0, 0, 0, 0, 8'h05, 8'hFF, 8'h3C, 8'h42, 0);
    // R8 page mode write
    txn(1, 1, 1, 0, 8'h80, 8'h99, 8'h21, 8'h5A, 0);
    // R2 stretched read and write
    txn(0, 1, 0, 1, 8'h11, 8'h22, 8'h00, 8'hB7, 0);
    txn(1, 0, 0, 1, 8'hF0, 8'h01, 8'hDE, 8'h0F, 0);
    // R10 requests during busy are ignored
    txn(1, 1, 0, 0, 8'h4D, 8'h4E, 8'h4F, 8'h61, 1);
    txn(0, 1, 1, 1, 8'h2A, 8'hAB, 8'hCD, 8'hE4, 1);
    repeat (5) @(negedge clk);
    chk(q.size() == 0 && !in_cyc, "R10 all accesses consumed", q.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule